// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple host port and a four-bank, 16-bit-wide synchronous DRAM. The host hands over one request at a time: a 24-bit word address, a read/write flag, a data word and a two-bit byte mask. The controller turns each request into a closed-page command sequence on the memory pins. It opens the row, issues the column access and then closes the bank again. Row and column share the multiplexed address bus, and the bank travels on its own select pins.

After reset the controller brings the memory up by itself. It waits a startup delay, precharges all banks, runs a configurable number of auto-refresh cycles and loads the mode register with the build-time CAS latency and read burst length. Only then does it accept work. An interval timer then requests one auto-refresh per period, and that refresh wins over a waiting host request. Writes always touch one word, with the two byte-mask pins blanking the bytes the host asked to keep. Reads return a burst of words, captured CAS-latency cycles after the memory sees the read command.

Top module: `sdr_ctrl`

## Requirements
- R1: The address splits as bank = bits 23:22, row = bits 21:9, column = bits 8:0. ACT drives the row on sd_addr[12:0] and the bank on sd_ba. READ and WRITE drive the column on sd_addr[8:0] with sd_addr[10] low and the same bank.
- R2: Commands on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} use only these codes: NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRE 0010, REF 0001, MRS 0000. The pins show NOP during reset.
- R3: After reset only NOP appears for at least T_INIT cycles. The bring-up then runs in order: one PRE with sd_addr[10] high, then INIT_REFS REF commands, then one MRS.
- R4: The MRS value on sd_addr has bits 2:0 = burst code (1→000, 2→001, 4→010, 8→011), bit 3 = 0 (sequential), bits 6:4 = CAS latency, bit 9 = 1 (single-word writes) and all other bits 0.
- R5: The command spacings are: ACT to READ/WRITE at least T_RCD cycles; PRE to ACT or REF at least T_RP; REF to any next command at least T_RFC; MRS to any next command at least T_MRD. REF is issued only with all banks closed.
- R6: Each read yields exactly RD_BURST words on rsp_data, each with a one-cycle rsp_valid pulse. Word k is taken from sd_dq_in CAS_LAT+k cycles after the memory samples READ. Word k comes from column (col & ~(RD_BURST-1)) | ((col+k) & (RD_BURST-1)).
- R7: A write issues exactly one WRITE. In that cycle sd_dq_oe is high, sd_dq_out carries the data and sd_dqm equals the host mask; mask bit 0 blocks the low byte and bit 1 the high byte. sd_dq_oe is low at all other times.
- R8: Each request opens one bank with ACT and closes it with PRE (sd_addr[10] low) before the next ACT. ACT never targets an open bank, and READ/WRITE only target an open bank.
- R9: After bring-up, no more than REF_INTERVAL plus the longest request sequence passes without a REF. This holds even when req_valid is held high continuously.
- R10: A request is taken on a cycle with req_valid and req_ready both high. req_ready stays low until bring-up completes and while a refresh or a request is in progress, so each handshake produces exactly one ACT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address {bank, row, col} |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, 1 blocks that byte |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | 16 | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Multiplexed row/column/mode bus |
| sd_dqm | output | 2 | Byte mask pins |
| sd_dq_out | output | 16 | Data toward memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The bench holds a behavioural memory that presents read data exactly CAS-latency cycles after it samples READ. Elsewhere the data lines carry a poison value, so a capture point that is off by one cycle returns poison instead of the stored word. Masked writes over known contents catch a swapped or inverted byte mask, which would leave the wrong half of a word changed on read-back. A read at an unaligned column checks the wrapped burst order, where a design that counts linearly would return a neighbouring block. A continuous stream of requests checks that refresh still gets through: a design that let requests win would starve refresh and break the interval bound. Every command is checked against open-bank state and spacing rules, so an early activate or a refresh over an open bank is flagged.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 13;
    localparam int COL_W  = 9;
    localparam int DQ_W   = 16;
    localparam int MASK_W = DQ_W / 8;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int NBANK  = 1 << BANK_W;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_BOOT, ST_BOOT_REF, ST_BOOT_MRS, ST_IDLE, ST_RW, ST_PRE
    } seq_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } word_addr_t;

    // request fields still needed after the row is opened
    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [DQ_W-1:0]   data;
        logic [MASK_W-1:0] mask;
    } held_op_t;

    typedef struct packed {
        sdr_cmd_e          cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic [MASK_W-1:0] dqm;
        logic              oe;
        logic [DQ_W-1:0]   dout;
    } pin_bus_t;

    localparam pin_bus_t PINS_IDLE = '{cmd: CMD_NOP, ba: '0, a: '0, dqm: '0, oe: 1'b0, dout: '0};

    function automatic logic [2:0] burst_code(input int bl);
        case (bl)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] mode_word(input int cl, input int bl);
        logic [ROW_W-1:0] w;
        w      = '0;
        w[2:0] = burst_code(bl);
        w[3]   = 1'b0;
        w[6:4] = 3'(cl);
        w[9]   = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sdr_wait_ctr.sv
module sdr_wait_ctr #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= W'(RST_VAL);
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
    parameter int INTERVAL = 975
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pend
);
    localparam int TW = $clog2(INTERVAL + 1);
    logic [TW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)     pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CL = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat,
    input  logic [DW-1:0] dq_in,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    logic [CL-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            pipe      <= {pipe[CL-2:0], beat};
            rsp_valid <= pipe[CL-1];
            if (pipe[CL-1]) rsp_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
    import sdr_ctrl_pkg::*;
#(
    parameter int CAS_LAT      = 3,
    parameter int RD_BURST     = 4,
    parameter int T_INIT       = 25000,
    parameter int T_RP         = 3,
    parameter int T_RCD        = 3,
    parameter int T_RFC        = 9,
    parameter int T_MRD        = 2,
    parameter int T_WR         = 2,
    parameter int INIT_REFS    = 2,
    parameter int REF_INTERVAL = 975
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_we,
    input  logic [23:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_mask,
    output logic        rsp_valid,
    output logic [15:0] rsp_data,
    output logic        sd_cs_n,
    output logic        sd_ras_n,
    output logic        sd_cas_n,
    output logic        sd_we_n,
    output logic [1:0]  sd_ba,
    output logic [12:0] sd_addr,
    output logic [1:0]  sd_dqm,
    output logic [15:0] sd_dq_out,
    output logic        sd_dq_oe,
    input  logic [15:0] sd_dq_in
);
    localparam int SPAN = T_INIT + T_RFC + T_RP + T_RCD + T_MRD + T_WR + RD_BURST + CAS_LAT;
    localparam int CW   = $clog2(SPAN + 1);
    localparam int BW   = $clog2(RD_BURST + 1);
    localparam int RW   = $clog2(INIT_REFS + 1);

    seq_state_e     state_q, state_d;
    held_op_t       op_q;
    pin_bus_t       pins_q, pins_d;
    logic [BW-1:0]  beats_q;
    logic [RW-1:0]  refs_q;
    logic           wait_done, load, ref_pend, ref_ack, take, rd_go, boot_ref;
    logic [CW-1:0]  load_val;
    word_addr_t     in_loc;

    assign in_loc = word_addr_t'(req_addr);

    sdr_wait_ctr #(.W(CW), .RST_VAL(T_INIT)) u_wait (
        .clk(clk), .rst(rst), .load(load), .val(load_val), .done(wait_done)
    );

    sdr_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
    );

    assign req_ready = (state_q == ST_IDLE) && wait_done && !ref_pend;

    always_comb begin
        state_d  = state_q;
        pins_d   = PINS_IDLE;
        load     = 1'b0;
        load_val = '0;
        ref_ack  = 1'b0;
        take     = 1'b0;
        rd_go    = 1'b0;
        boot_ref = 1'b0;
        if (wait_done) begin
            case (state_q)
                ST_BOOT: begin
                    pins_d.cmd   = CMD_PRE;
                    pins_d.a[10] = 1'b1;
                    load         = 1'b1;
                    load_val     = CW'(T_RP - 1);
                    state_d      = ST_BOOT_REF;
                end
                ST_BOOT_REF: begin
                    pins_d.cmd = CMD_REF;
                    load       = 1'b1;
                    load_val   = CW'(T_RFC - 1);
                    boot_ref   = 1'b1;
                    if (refs_q == RW'(INIT_REFS - 1)) state_d = ST_BOOT_MRS;
                end
                ST_BOOT_MRS: begin
                    pins_d.cmd = CMD_MRS;
                    pins_d.a   = mode_word(CAS_LAT, RD_BURST);
                    load       = 1'b1;
                    load_val   = CW'(T_MRD - 1);
                    state_d    = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        pins_d.cmd = CMD_REF;
                        load       = 1'b1;
                        load_val   = CW'(T_RFC - 1);
                        ref_ack    = 1'b1;
                    end else if (req_valid) begin
                        take       = 1'b1;
                        pins_d.cmd = CMD_ACT;
                        pins_d.ba  = in_loc.bank;
                        pins_d.a   = in_loc.row;
                        load       = 1'b1;
                        load_val   = CW'(T_RCD - 1);
                        state_d    = ST_RW;
                    end
                end
                ST_RW: begin
                    pins_d.ba         = op_q.bank;
                    pins_d.a[COL_W-1:0] = op_q.col;
                    load              = 1'b1;
                    state_d           = ST_PRE;
                    if (op_q.wr) begin
                        pins_d.cmd  = CMD_WR;
                        pins_d.dqm  = op_q.mask;
                        pins_d.oe   = 1'b1;
                        pins_d.dout = op_q.data;
                        load_val    = CW'(T_WR - 1);
                    end else begin
                        pins_d.cmd = CMD_RD;
                        rd_go      = 1'b1;
                        load_val   = CW'(RD_BURST + CAS_LAT - 1);
                    end
                end
                ST_PRE: begin
                    pins_d.cmd = CMD_PRE;
                    pins_d.ba  = op_q.bank;
                    load       = 1'b1;
                    load_val   = CW'(T_RP - 1);
                    state_d    = ST_IDLE;
                end
                default: state_d = ST_BOOT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            pins_q  <= PINS_IDLE;
            op_q    <= '0;
            beats_q <= '0;
            refs_q  <= '0;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_d;
            if (take)
                op_q <= '{wr: req_we, bank: in_loc.bank, col: in_loc.col,
                          data: req_wdata, mask: req_mask};
            if (rd_go)               beats_q <= BW'(RD_BURST);
            else if (beats_q != '0)  beats_q <= beats_q - 1'b1;
            if (boot_ref)            refs_q  <= refs_q + 1'b1;
        end
    end

    sdr_rd_capture #(.CL(CAS_LAT), .DW(DQ_W)) u_cap (
        .clk(clk), .rst(rst), .beat(beats_q != '0), .dq_in(sd_dq_in),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins_q.cmd;
    assign sd_ba     = pins_q.ba;
    assign sd_addr   = pins_q.a;
    assign sd_dqm    = pins_q.dqm;
    assign sd_dq_out = pins_q.dout;
    assign sd_dq_oe  = pins_q.oe;
endmodule

// File: rtl/sdr_ctrl_chk.sv
module sdr_ctrl_chk
    import sdr_ctrl_pkg::*;
#(
    parameter int T_INIT       = 25000,
    parameter int T_RP         = 3,
    parameter int T_RCD        = 3,
    parameter int T_RFC        = 9,
    parameter int T_WR         = 2,
    parameter int RD_BURST     = 4,
    parameter int CAS_LAT      = 3,
    parameter int REF_INTERVAL = 975
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [1:0] ba,
    input logic       a10,
    input logic       dq_oe,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid
);
    localparam int SLACK = T_RCD + T_WR + RD_BURST + CAS_LAT + T_RP + T_RFC + 4;
    localparam int LIMIT = REF_INTERVAL + SLACK;
    localparam int GW    = $clog2(T_INIT + LIMIT + 2) + 1;
    localparam int OW    = $clog2(2 * RD_BURST + 1);

    logic [3:0]       cmd;
    logic [GW-1:0]    act_gap, pre_gap, ref_gap;
    logic [NBANK-1:0] open_q;
    logic [OW-1:0]    outs;
    logic             boot_done;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            act_gap   <= '1;
            pre_gap   <= '1;
            ref_gap   <= '1;
            open_q    <= '0;
            outs      <= '0;
            boot_done <= 1'b0;
        end else begin
            act_gap <= (cmd == CMD_ACT) ? GW'(1) : ((act_gap == '1) ? act_gap : act_gap + 1'b1);
            pre_gap <= (cmd == CMD_PRE) ? GW'(1) : ((pre_gap == '1) ? pre_gap : pre_gap + 1'b1);
            ref_gap <= (cmd == CMD_REF) ? GW'(1) : ((ref_gap == '1) ? ref_gap : ref_gap + 1'b1);
            if (cmd == CMD_ACT) open_q[ba] <= 1'b1;
            if (cmd == CMD_PRE) begin
                if (a10) open_q <= '0;
                else     open_q[ba] <= 1'b0;
            end
            outs <= outs + ((cmd == CMD_RD) ? OW'(RD_BURST) : '0) - (rsp_valid ? OW'(1) : '0);
            if (cmd == CMD_MRS) boot_done <= 1'b1;
        end
    end

    a_r1_no_autopre: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> !a10)
        else $error("R1 column command with auto-precharge bit");

    a_r5_rcd: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> act_gap >= GW'(T_RCD))
        else $error("R5 activate to column spacing");

    a_r5_rp: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT || cmd == CMD_REF) |-> pre_gap >= GW'(T_RP))
        else $error("R5 precharge spacing");

    a_r5_rfc: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> ref_gap >= GW'(T_RFC))
        else $error("R5 refresh cycle time");

    a_r5_ref_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> open_q == '0)
        else $error("R5 refresh with open bank");

    a_r8_act_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> !open_q[ba])
        else $error("R8 activate on open bank");

    a_r8_rw_open: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> open_q[ba])
        else $error("R8 column command on closed bank");

    a_r7_oe_with_write: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> cmd == CMD_WR)
        else $error("R7 data driven outside write");

    a_r6_rsp_expected: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> outs != '0)
        else $error("R6 response without read");

    a_r6_burst_drained: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD) |-> outs == '0)
        else $error("R6 read before previous burst drained");

    a_r9_ref_interval: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> ref_gap <= GW'(LIMIT))
        else $error("R9 refresh interval exceeded");

    a_r10_ready_after_boot: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> boot_done)
        else $error("R10 request taken before bring-up");
endmodule

bind sdr_ctrl sdr_ctrl_chk #(
    .T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .T_WR(T_WR),
    .RD_BURST(RD_BURST), .CAS_LAT(CAS_LAT), .REF_INTERVAL(REF_INTERVAL)
) u_chk (
    .clk(clk), .rst(rst), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .ba(sd_ba), .a10(sd_addr[10]), .dq_oe(sd_dq_oe),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/sdr_ctrl_tb.sv
module sdr_ctrl_tb;
    import sdr_ctrl_pkg::*;

    localparam int CL = 3, BL = 4, TI = 20, RI = 150;
    localparam int TRP = 3, TRCD = 3, TRFC = 9, TMRD = 2, TWR = 2, NREF = 2;
    localparam int SLACK = TRCD + TWR + BL + CL + TRP + TRFC + 4;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_data;
    logic        cs_n, ras_n, cas_n, we_n, dq_oe;
    logic [1:0]  ba, dqm;
    logic [12:0] sa;
    logic [15:0] dq_out;
    logic [15:0] dq_in = 16'hdead;

    sdr_ctrl #(.CAS_LAT(CL), .RD_BURST(BL), .T_INIT(TI), .T_RP(TRP), .T_RCD(TRCD),
               .T_RFC(TRFC), .T_MRD(TMRD), .T_WR(TWR), .INIT_REFS(NREF),
               .REF_INTERVAL(RI)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
        .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_addr(sa), .sd_dqm(dqm),
        .sd_dq_out(dq_out), .sd_dq_oe(dq_oe), .sd_dq_in(dq_in)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], 8'h5a};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] m);
        return {m[1] ? old[15:8] : d[15:8], m[0] ? old[7:0] : d[7:0]};
    endfunction

    typedef struct {bit we; logic [23:0] a; logic [15:0] d; logic [1:0] m;} rq_t;
    typedef struct {int when; logic [15:0] d;} beat_t;

    logic [15:0] shadow [int];
    logic [15:0] mem [int];
    logic [15:0] exp_q [$];
    rq_t         req_log [$];
    beat_t       rdq [$];

    // scoreboard driver
    task automatic do_req(input bit we, input logic [23:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        rq_t r;
        logic [15:0] old;
        req_we = we; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        r = '{we: we, a: a, d: d, m: m};
        req_log.push_back(r);
        if (we) begin
            old = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
            shadow[int'(a)] = merge(old, d, m);
        end else begin
            for (int k = 0; k < BL; k++) begin
                logic [8:0]  c;
                logic [23:0] ak;
                c  = (a[8:0] & ~9'(BL - 1)) | ((a[8:0] + 9'(k)) & 9'(BL - 1));
                ak = {a[23:9], c};
                exp_q.push_back(shadow.exists(int'(ak)) ? shadow[int'(ak)] : init_word(ak));
            end
        end
        @(negedge clk);
    endtask

    // memory model
    int  cyc = 0, boot_idx = 0, since_ref = 1000, since_mrs = 1000, max_gap = 0, nref = 0;
    int  since_act [4] = '{1000, 1000, 1000, 1000};
    int  since_pre [4] = '{1000, 1000, 1000, 1000};
    bit  open_b [4] = '{0, 0, 0, 0};
    logic [12:0] open_row [4];
    bit  mrs_seen = 0, first_cmd = 0;
    rq_t cur;

    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] c4;
            cyc++;
            since_ref++; since_mrs++;
            for (int b = 0; b < 4; b++) begin since_act[b]++; since_pre[b]++; end
            if (rdq.size() > 0 && rdq[0].when == cyc) begin
                dq_in = rdq[0].d;
                void'(rdq.pop_front());
            end else begin
                dq_in = 16'hdead;
            end
            c4 = {cs_n, ras_n, cas_n, we_n};
            if (c4 != 4'b0111 && !first_cmd) begin
                first_cmd = 1;
                chk(cyc >= TI, "R3", "first command cycle", cyc, TI);
            end
            if (c4 != 4'b0111 && boot_idx < 4) begin
                case (boot_idx)
                    0: chk(c4 == 4'b0010 && sa[10], "R3", "bring-up precharge-all", {c4, sa}, {4'b0010, 13'h400});
                    1, 2: chk(c4 == 4'b0001, "R3", "bring-up refresh", c4, 4'b0001);
                    default: begin
                        chk(c4 == 4'b0000, "R3", "bring-up mode load", c4, 4'b0000);
                        chk(sa == 13'b0_0010_0011_0010, "R4", "mode value", sa, 13'b0_0010_0011_0010);
                    end
                endcase
                boot_idx++;
            end
            if (!mrs_seen) chk(!req_ready, "R10", "ready during bring-up", req_ready, 0);
            if (c4 != 4'b0100) chk(!dq_oe, "R7", "output enable outside write", dq_oe, 0);
            case (c4)
                4'b0111: ;
                4'b0011: begin
                    chk(!open_b[ba], "R8", "activate on open bank", open_b[ba], 0);
                    chk(since_pre[ba] >= TRP, "R5", "precharge to activate", since_pre[ba], TRP);
                    chk(since_ref >= TRFC, "R5", "refresh to activate", since_ref, TRFC);
                    chk(since_mrs >= TMRD, "R5", "mode load to activate", since_mrs, TMRD);
                    if (req_log.size() == 0) begin
                        chk(0, "R10", "activate without handshake", 1, 0);
                    end else begin
                        cur = req_log.pop_front();
                        chk(ba == cur.a[23:22] && sa == cur.a[21:9], "R1", "activate bank/row",
                            {ba, sa}, {cur.a[23:22], cur.a[21:9]});
                    end
                    open_b[ba] = 1; open_row[ba] = sa; since_act[ba] = 0;
                end
                4'b0101, 4'b0100: begin
                    logic [23:0] wa;
                    chk(open_b[ba], "R8", "column command on closed bank", open_b[ba], 1);
                    chk(since_act[ba] >= TRCD, "R5", "activate to column", since_act[ba], TRCD);
                    chk(!sa[10] && sa[8:0] == cur.a[8:0] && ba == cur.a[23:22], "R1",
                        "column address", {ba, sa}, {cur.a[23:22], 4'b0, cur.a[8:0]});
                    wa = {ba, open_row[ba], sa[8:0]};
                    if (c4 == 4'b0100) begin
                        logic [15:0] old;
                        chk(dq_oe && dq_out == cur.d && dqm == cur.m, "R7", "write pins",
                            {dq_oe, dqm, dq_out}, {1'b1, cur.m, cur.d});
                        old = mem.exists(int'(wa)) ? mem[int'(wa)] : init_word(wa);
                        mem[int'(wa)] = merge(old, dq_out, dqm);
                    end else begin
                        for (int k = 0; k < BL; k++) begin
                            logic [8:0]  cc;
                            logic [23:0] ak;
                            beat_t bt;
                            cc = (sa[8:0] & ~9'(BL - 1)) | ((sa[8:0] + 9'(k)) & 9'(BL - 1));
                            ak = {wa[23:9], cc};
                            bt.when = cyc + CL + k;
                            bt.d = mem.exists(int'(ak)) ? mem[int'(ak)] : init_word(ak);
                            rdq.push_back(bt);
                        end
                    end
                end
                4'b0010: begin
                    if (mrs_seen) chk(!sa[10], "R8", "request precharge single bank", sa[10], 0);
                    for (int b = 0; b < 4; b++)
                        if (sa[10] || b == int'(ba)) begin open_b[b] = 0; since_pre[b] = 0; end
                end
                4'b0001: begin
                    chk(!open_b[0] && !open_b[1] && !open_b[2] && !open_b[3], "R5",
                        "refresh with open bank", {open_b[3], open_b[2], open_b[1], open_b[0]}, 0);
                    chk(since_ref >= TRFC, "R5", "refresh to refresh", since_ref, TRFC);
                    if (mrs_seen) nref++;
                    since_ref = 0;
                end
                4'b0000: begin mrs_seen = 1; since_mrs = 0; end
                default: chk(0, "R2", "illegal command code", c4, 4'b0111);
            endcase
            if (mrs_seen && since_ref > max_gap) max_gap = since_ref;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) chk(0, "R6", "unexpected read word", rsp_data, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rsp_data == e, "R6", "read word", rsp_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2", "NOP in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(!req_ready && !rsp_valid && !dq_oe, "R3", "idle outputs in reset",
            {req_ready, rsp_valid, dq_oe}, 0);
        rst = 1'b0;
        // first request waits through bring-up
        do_req(1, 24'h000000, 16'h1234, 2'b00);
        do_req(1, 24'h400010, 16'hAAAA, 2'b00);
        do_req(1, 24'h400010, 16'h5555, 2'b01);
        do_req(1, 24'h800020, 16'hCAFE, 2'b00);
        do_req(1, 24'h800020, 16'h0F0F, 2'b10);
        do_req(1, 24'hC00030, 16'hBEEF, 2'b11);
        do_req(1, 24'hFFFFFF, 16'h7E57, 2'b00);
        do_req(1, 24'h200102, 16'h0102, 2'b00);
        do_req(0, 24'h000000, '0, 2'b00);
        do_req(0, 24'h400010, '0, 2'b00);
        do_req(0, 24'h800020, '0, 2'b00);
        do_req(0, 24'hC00030, '0, 2'b00);
        do_req(0, 24'hFFFFFF, '0, 2'b00);
        do_req(0, 24'h200102, '0, 2'b00);
        do_req(0, 24'h3FFE05, '0, 2'b00);
        // continuous stream keeps req_valid high across refresh ticks
        for (int i = 0; i < 48; i++) begin
            logic [23:0] a;
            a = {2'(i), 13'(i * 37), 9'(i * 11)};
            do_req(i % 3 == 0, a, 16'(i * 16'h0101 + 3), 2'(i));
        end
        req_valid = 1'b0;
        repeat (60) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "all read words returned", exp_q.size(), 0);
        chk(req_log.size() == 0, "R10", "one activate per handshake", req_log.size(), 0);
        chk(nref >= 3, "R9", "refreshes after bring-up", nref, 3);
        chk(max_gap <= RI + SLACK, "R9", "longest refresh gap", max_gap, RI + SLACK);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule